// File: doc/BRIEF.md
# Data-Ready Triggered Multichannel Frame Reader

This block is an SPI master that pulls conversion results out of a multichannel delta-sigma converter running in continuous-read mode. It watches the converter's active-low data-ready line. Each new result set is announced by a falling edge on that line. When the block sees that edge, it runs one fixed-length read. The read is a 24-bit status word followed by one 24-bit sample for every channel. The block sends each finished word out as a single-cycle valid pulse, with the data widened to 32 bits and an index that gives the word's place in the frame.

The serial link uses mode 1: SCLK idles low, the converter shifts a bit out on each rising edge, and the block samples the bit on the following falling edge, most significant bit first. A parameter sets the SCLK half-period as a whole number of system clocks. A configuration input picks how chip select behaves. In one mode it is pulled low only around each frame. In the other it is held low all the time. A sticky flag records a data-ready edge that arrives before the current frame is finished. Only reset clears it.

The controller is a four-state machine:
- `ST_IDLE` waits for a data-ready edge.
- `ST_LEAD` gives one half-period of chip-select setup. It is entered only in per-frame select mode.
- `ST_SHIFT` generates the SCLK cycles.
- `ST_TRAIL` gives one half-period of hold after the last falling edge.

The transitions are:
- `ST_IDLE` to `ST_LEAD` on an edge in per-frame mode.
- `ST_IDLE` to `ST_SHIFT` on an edge in held-select mode.
- `ST_LEAD` to `ST_SHIFT` on a half-period tick.
- `ST_SHIFT` to `ST_TRAIL` when the last bit has been sampled.
- `ST_TRAIL` to `ST_IDLE` on a half-period tick.

Top module: `cvt_frame_reader`

## Requirements
- R1: A frame starts only on a falling edge of `drdy_n`, seen after a two-flop synchroniser. Holding `drdy_n` low, or letting it rise, starts nothing more.
- R2: Each frame produces exactly 24×(N_CH+1) SCLK rising edges. SCLK is low whenever no frame is in progress.
- R3: Each bit is taken from `miso` on an SCLK falling edge. The first bit of each 24-bit word is its most significant bit.
- R4: Each completed word raises `word_vld` for exactly one clock cycle. `word_idx` is 0 for the status word and 1 to N_CH for the channels, in order of arrival.
- R5: `word_data` holds the status word (index 0) zero-extended to 32 bits. It holds each channel word (index 1 and up) sign-extended from bit 23.
- R6: With `cs_per_xfer` = 1, `cs_n` is high while idle. It goes low before the first SCLK rising edge of a frame and returns high after the frame's last SCLK falling edge.
- R7: With `cs_per_xfer` = 0, `cs_n` is low from the second clock after that setting is applied. It stays low through frames and idle time.
- R8: A `drdy_n` falling edge during a frame sets `overrun`. The flag stays set until reset. The current frame completes with its full bit count and correct words, and that edge does not start a further frame.
- R9: While and after reset, `cs_n` is high, `sclk` is low, `word_vld` is low and `overrun` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| cs_per_xfer | input | 1 | 1: select pulsed around each frame; 0: select held low |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| word_vld | output | 1 | One-cycle strobe for a completed word |
| word_idx | output | $clog2(N_CH+1) | Word position: 0 status, 1..N_CH channels |
| word_data | output | 32 | Extended word value |
| overrun | output | 1 | Sticky: data-ready edge seen during a frame |

## Verification
The hardest case to reach from the ports is the overrun: a second falling edge on data-ready that lands while the shift engine is partway through a frame. The stimulus pulses data-ready high and low again about a hundred cycles into a frame. It then checks three things: the flag rises, the bit count and every word of the interrupted frame are still exact, and no extra frame follows. Random frames use channel values that include the sign boundaries, so the extension rules are exercised at their edges. The frames alternate between the two chip-select modes.

// File: rtl/frd_pkg.sv
package frd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } rd_state_e;

endpackage

// File: rtl/frd_edge_det.sv
// Synchronises an asynchronous active-low strobe and flags its falling edge.
module frd_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic fall_pulse
);

    // pipe[0..STAGES-1] are synchroniser flops, pipe[STAGES] holds history
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-1:0], async_n};
        end
    end

    assign fall_pulse = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/frd_half_timer.sv
// Emits a tick every HALF_DIV clocks while run is high; restarts when run drops.
module frd_half_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/frd_word_shifter.sv
// Collects bits MSB first and reports each full word.
module frd_word_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample_en,
    input  logic              din,
    output logic              word_done,
    output logic [WORD_W-1:0] word_raw
);

    localparam int BCW = $clog2(WORD_W);

    logic [WORD_W-2:0] sh;
    logic [BCW-1:0]    bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '0;
            bcnt      <= '0;
            word_done <= 1'b0;
            word_raw  <= '0;
        end else begin
            word_done <= 1'b0;
            if (clear) begin
                bcnt <= '0;
            end else if (sample_en) begin
                sh <= {sh[WORD_W-3:0], din};
                if (bcnt == BCW'(WORD_W - 1)) begin
                    bcnt      <= '0;
                    word_done <= 1'b1;
                    word_raw  <= {sh, din};
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cvt_frame_reader.sv
module cvt_frame_reader
    import frd_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int WORD_W      = 24,
    parameter int OUT_W       = 32,
    parameter int HALF_DIV    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(N_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drdy_n,
    input  logic             cs_per_xfer,
    input  logic             miso,
    output logic             sclk,
    output logic             cs_n,
    output logic             word_vld,
    output logic [IDX_W-1:0] word_idx,
    output logic [OUT_W-1:0] word_data,
    output logic             overrun
);

    localparam int N_WORDS    = N_CH + 1;
    localparam int TOTAL_BITS = WORD_W * N_WORDS;
    localparam int BIT_CW     = $clog2(TOTAL_BITS);
    localparam int PAD_W      = OUT_W - WORD_W;

    rd_state_e state_q, state_d;

    logic              drdy_fall;
    logic              tick;
    logic              sclk_q;
    logic              cs_n_q;
    logic [BIT_CW-1:0] bit_cnt;
    logic [IDX_W-1:0]  cur_idx;
    logic              word_done;
    logic [WORD_W-1:0] word_raw;
    logic [OUT_W-1:0]  word_ext;
    logic              vld_q;
    logic [IDX_W-1:0]  idx_q;
    logic [OUT_W-1:0]  data_q;
    logic              ovr_q;
    logic              start;
    logic              sample_en;
    logic              last_bit;

    frd_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_n    (drdy_n),
        .fall_pulse (drdy_fall)
    );

    frd_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .tick  (tick)
    );

    frd_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .sample_en (sample_en),
        .din       (miso),
        .word_done (word_done),
        .word_raw  (word_raw)
    );

    assign start     = (state_q == ST_IDLE) && drdy_fall;
    assign sample_en = (state_q == ST_SHIFT) && tick && sclk_q;
    assign last_bit  = (bit_cnt == BIT_CW'(TOTAL_BITS - 1));

    // Status word is zero-extended, channel samples are sign-extended
    always_comb begin
        if (cur_idx == '0) begin
            word_ext = {{PAD_W{1'b0}}, word_raw};
        end else begin
            word_ext = {{PAD_W{word_raw[WORD_W-1]}}, word_raw};
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (drdy_fall) begin
                    state_d = cs_per_xfer ? ST_LEAD : ST_SHIFT;
                end
            end
            ST_LEAD: begin
                if (tick) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sample_en && last_bit) state_d = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (tick) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered outputs and datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            bit_cnt <= '0;
            cur_idx <= '0;
            vld_q   <= 1'b0;
            idx_q   <= '0;
            data_q  <= '0;
            ovr_q   <= 1'b0;
        end else begin
            cs_n_q <= cs_per_xfer ? (state_d == ST_IDLE) : 1'b0;

            if (state_q == ST_SHIFT) begin
                if (tick) sclk_q <= ~sclk_q;
            end else begin
                sclk_q <= 1'b0;
            end

            if (start) begin
                bit_cnt <= '0;
                cur_idx <= '0;
            end else begin
                if (sample_en) bit_cnt <= bit_cnt + 1'b1;
                if (word_done) cur_idx <= cur_idx + 1'b1;
            end

            vld_q <= word_done;
            if (word_done) begin
                idx_q  <= cur_idx;
                data_q <= word_ext;
            end

            if (drdy_fall && (state_q != ST_IDLE)) ovr_q <= 1'b1;
        end
    end

    assign sclk      = sclk_q;
    assign cs_n      = cs_n_q;
    assign word_vld  = vld_q;
    assign word_idx  = idx_q;
    assign word_data = data_q;
    assign overrun   = ovr_q;

endmodule

// File: rtl/frd_checker.sv
module frd_checker #(
    parameter int N_CH   = 4,
    parameter int WORD_W = 24,
    parameter int OUT_W  = 32,
    parameter int IDX_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_per_xfer,
    input logic             sclk,
    input logic             cs_n,
    input logic             word_vld,
    input logic [IDX_W-1:0] word_idx,
    input logic [OUT_W-1:0] word_data,
    input logic             overrun
);

    // R2 / R6: no clock while deselected in per-frame mode
    a_r2_sclk_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_per_xfer && cs_n) |-> !sclk);

    // R4: valid is a single-cycle strobe
    a_r4_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    // R4: index within the frame
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (word_idx <= IDX_W'(N_CH)));

    // R5: status word carries zero upper bits
    a_r5_status_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_idx == '0) |-> (word_data[OUT_W-1:WORD_W] == '0));

    // R5: channel words replicate bit 23 upward
    a_r5_sample_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_idx != '0) |->
        ($countones(word_data[OUT_W-1:WORD_W-1]) == 0 ||
         $countones(word_data[OUT_W-1:WORD_W-1]) == OUT_W - WORD_W + 1));

    // R7: held-select mode keeps select low
    a_r7_hold_select: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_per_xfer |=> !cs_n);

    // R8: overrun flag is sticky
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind cvt_frame_reader frd_checker #(
    .N_CH   (N_CH),
    .WORD_W (WORD_W),
    .OUT_W  (OUT_W),
    .IDX_W  (IDX_W)
) u_frd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_per_xfer (cs_per_xfer),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .word_vld    (word_vld),
    .word_idx    (word_idx),
    .word_data   (word_data),
    .overrun     (overrun)
);

// File: tb/sim_cvt_frame_reader.sv
`timescale 1ns/1ps
module sim_cvt_frame_reader;

    localparam int N_CH    = 4;
    localparam int N_WORDS = N_CH + 1;
    localparam int TOTAL   = 24 * N_WORDS;
    localparam int IDX_W   = $clog2(N_CH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drdy_n = 1'b1;
    logic cs_per_xfer = 1'b1;
    logic miso = 1'b0;
    logic sclk, cs_n, word_vld, overrun;
    logic [IDX_W-1:0] word_idx;
    logic [31:0] word_data;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int edges = 0;
    int got = 0;
    int ptr = 0;
    int cs_bad = 0;
    bit hold_watch = 1'b0;
    logic [23:0] exp_w [0:N_CH];

    always #2 clk = ~clk;

    cvt_frame_reader #(.N_CH(N_CH)) u0 (
        .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .cs_per_xfer(cs_per_xfer),
        .miso(miso), .sclk(sclk), .cs_n(cs_n), .word_vld(word_vld),
        .word_idx(word_idx), .word_data(word_data), .overrun(overrun)
    );

    function automatic logic [31:0] ext_word(int idx, logic [23:0] w);
        if (idx == 0) return {8'h00, w};
        return {{8{w[23]}}, w};
    endfunction

    function automatic logic frame_bit(int k);
        logic [23:0] w;
        w = exp_w[k / 24];
        return w[23 - (k % 24)];
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Converter model: drives the next bit on each SCLK rising edge (mode 1)
    always @(posedge sclk) begin
        edges++;
        if (cs_n) cs_bad++;
        #1;
        if (ptr < TOTAL) miso = frame_bit(ptr);
        ptr++;
    end

    // Word monitor (R3, R4, R5)
    always @(negedge clk) begin
        if (hold_watch && cs_n) cs_bad++;
        if (word_vld) begin
            if (got <= N_CH) begin
                check(word_idx == IDX_W'(got), "R4", "word index", word_idx, got);
                check(word_data == ext_word(got, exp_w[got]), "R3/R5", "word data",
                      word_data, ext_word(got, exp_w[got]));
            end else begin
                check(1'b0, "R4", "extra word", got, N_CH);
            end
            got++;
        end
    end

    // Watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(bit per_xfer, bit overlap, int dir);
        int e_after;
        @(negedge clk);
        cs_per_xfer = per_xfer;
        hold_watch = 1'b0;
        wait_clks(3);
        hold_watch = !per_xfer;
        for (int i = 0; i <= N_CH; i++) exp_w[i] = 24'($urandom);
        if (dir == 1) begin
            exp_w[1] = 24'h800000; exp_w[2] = 24'h7FFFFF;
            exp_w[3] = 24'hFFFFFF; exp_w[4] = 24'h000000;
        end
        if (dir == 2) exp_w[0] = 24'hFFFFFF;
        ptr = 0; edges = 0; got = 0; cs_bad = 0;
        drdy_n = 1'b0;
        if (overlap) begin
            wait_clks(100);
            drdy_n = 1'b1;
            wait_clks(6);
            drdy_n = 1'b0;
            wait_clks(6);
            drdy_n = 1'b1;
        end else begin
            wait_clks(30 + int'($urandom_range(0, 40)));
            drdy_n = 1'b1;
        end
        for (int i = 0; i < 2000 && got < N_WORDS; i++) @(negedge clk);
        wait_clks(10);
        check(edges == TOTAL, "R2", "sclk edges per frame", edges, TOTAL);
        check(got == N_WORDS, "R4", "word count", got, N_WORDS);
        check(cs_bad == 0, per_xfer ? "R6" : "R7", "select low during clocking", cs_bad, 0);
        check(cs_n == per_xfer, per_xfer ? "R6" : "R7", "idle select level", cs_n, per_xfer);
        check(sclk == 1'b0, "R2", "sclk idle low", sclk, 0);
        e_after = edges;
        wait_clks(600);
        check(edges == e_after, overlap ? "R8" : "R1", "no extra frame", edges, e_after);
        if (overlap) check(overrun == 1'b1, "R8", "overrun set", overrun, 1);
        else         check(overrun == 1'b0, "R8", "no false overrun", overrun, 0);
    endtask

    task automatic check_reset_state();
        check(cs_n == 1'b1, "R9", "reset cs_n", cs_n, 1);
        check(sclk == 1'b0, "R9", "reset sclk", sclk, 0);
        check(word_vld == 1'b0, "R9", "reset word_vld", word_vld, 0);
        check(overrun == 1'b0, "R9", "reset overrun", overrun, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i <= N_CH; i++) exp_w[i] = '0;
        wait_clks(5);
        check_reset_state();
        rst_n = 1'b1;
        wait_clks(50);
        check_reset_state();
        check(edges == 0, "R1", "no clocking without data-ready", edges, 0);

        run_frame(1'b1, 1'b0, 1);
        run_frame(1'b0, 1'b0, 1);
        run_frame(1'b1, 1'b0, 2);
        for (int f = 0; f < 16; f++) begin
            run_frame(f[0], 1'b0, 0);
        end

        run_frame(1'b1, 1'b1, 0);
        run_frame(1'b0, 1'b1, 1);

        @(negedge clk);
        rst_n = 1'b0;
        cs_per_xfer = 1'b1;
        hold_watch = 1'b0;
        wait_clks(3);
        check_reset_state();
        rst_n = 1'b1;
        wait_clks(5);
        check(overrun == 1'b0, "R9", "overrun cleared by reset", overrun, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule